// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block puts a set of general-purpose pins behind an APB3 slave port with a 12-bit address and 32-bit data. Each pin drives a tri-state pad through a separate output value and output enable. Pad inputs pass through a chain of synchronizing registers whose length is a parameter. Software first reads a fixed header that identifies the block and reports how many pins and banks it has. It then reaches the pins through one register set per bank of up to 32 pins.

Parameters set which pins may drive their pads and which pins may be read. Bits for pins that lack a capability, and bits beyond the pin count, always read as zero. The pad enable can be made active low for pads that need it. Within each bank, the eight words after the input, output and direction words belong to an interrupt detector that lives outside this block. Their accesses pass straight through a register port: a write strobe with bank and word index, and a read-data return.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Word 0x000 reads {8'h00, 8'h08, IP_ID} and word 0x004 reads {8'h01, 8'h00, 16'h0000}.
- R2: Word 0x008 reads the bank count, ceil(WIDTH/32), in bits 31:16 and WIDTH in bits 15:0.
- R3: Bank b starts at byte 0x00C + 0x2C*b. Offset +0x0 is input (read only), +0x4 is output and +0x8 is direction. Output and direction hold the written value on their implemented bits.
- R4: pad_out follows the output register. The active pad enable is given only when the direction bit is 1 and the pin can output. Direction 0, or a pin without output capability, leaves the pad in high impedance.
- R5: In the output and direction words, bits of pins without output capability read 0. In the input word, bits of pins without input capability read 0. Bits at or above WIDTH read 0 in every bank word.
- R6: When OE_ACTIVE_LOW is 1, pad_oe is the bitwise inverse of the enable in R4.
- R7: pin_level and the input word show pad_in delayed by exactly SYNC_STAGES clock edges, masked by input capability. With SYNC_STAGES = 0 there is no delay.
- R8: pready is always 1. pslverr is 1 in the access phase of any access past the last bank, and of any write to a header word or to an input word. A write flagged with pslverr changes no register.
- R9: Bank offsets +0x0C to +0x28 map to external word index 0 to 7. A write there pulses reg_wr for its access cycle, with reg_bank, reg_idx and reg_wdata valid. A read there returns reg_rdata.
- R10: After reset the output and direction registers are 0, so every pin is an undriven input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and logic clock |
| presetn | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Error for unmapped or read-only access |
| pad_in | input | WIDTH | Raw pad input levels |
| pad_out | output | WIDTH | Pad output values |
| pad_oe | output | WIDTH | Pad output enables, polarity set by OE_ACTIVE_LOW |
| pin_level | output | WIDTH | Synchronized, capability-masked input levels |
| reg_wr | output | 1 | Write strobe for the external interrupt word window |
| reg_bank | output | 8 | Bank of the external word being accessed |
| reg_idx | output | 3 | External word index inside the bank |
| reg_wdata | output | 32 | Write data for the external word |
| reg_rdata | input | 32 | Read data from the external word |

## Verification
The assertions assume that APB transfers follow the protocol: psel is held with stable address and data through the setup and access phases, and penable is high for exactly one cycle. The bench drives every transfer through one task that builds this two-phase sequence at falling edges. pad_in changes only at falling edges, so the synchronizer's delay can be counted edge by edge. The external interrupt block is stood in for by a constant reg_rdata, which is enough to check that reads are routed to it.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int WIDTH = 40,
  parameter int SYNC_STAGES = 2,
  parameter logic [WIDTH-1:0] OUT_CAP = '1,
  parameter logic [WIDTH-1:0] IN_CAP = '1,
  parameter bit OE_ACTIVE_LOW = 1'b0,
  parameter logic [15:0] IP_ID = 16'h0000
) (
  input  logic             pclk,
  input  logic             presetn,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [11:0]      paddr,
  input  logic [31:0]      pwdata,
  output logic [31:0]      prdata,
  output logic             pready,
  output logic             pslverr,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pin_level,
  output logic             reg_wr,
  output logic [7:0]       reg_bank,
  output logic [2:0]       reg_idx,
  output logic [31:0]      reg_wdata,
  input  logic [31:0]      reg_rdata
);
  localparam int NB  = (WIDTH + 31) / 32;
  localparam int TOT = NB * 32;
  localparam int BW  = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [TOT-1:0] OCAP = TOT'(OUT_CAP);
  localparam logic [TOT-1:0] ICAP = TOT'(IN_CAP);

  logic [WIDTH-1:0] level;
  logic [TOT-1:0]   out_q, dir_q, in_all;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign level = pad_in;
    end else begin : g_sync
      logic [WIDTH-1:0] st [SYNC_STAGES];
      always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
          for (int i = 0; i < SYNC_STAGES; i++) st[i] <= '0;
        end else begin
          st[0] <= pad_in;
          for (int i = 1; i < SYNC_STAGES; i++) st[i] <= st[i-1];
        end
      end
      assign level = st[SYNC_STAGES-1];

      p_first_stage_r7: assert property (@(posedge pclk) disable iff (!presetn)
        1'b1 |=> st[0] == $past(pad_in));
    end
  endgenerate

  assign pin_level = level & IN_CAP;
  assign in_all    = TOT'(pin_level);

  wire [9:0] word    = paddr[11:2];
  wire       hdr     = word < 10'd3;
  wire [9:0] off     = word - 10'd3;
  wire [9:0] bank    = off / 10'd11;
  wire [3:0] idx     = 4'(off % 10'd11);
  wire       bank_ok = !hdr && (bank < 10'(NB));
  wire [BW-1:0] bsel = BW'(bank);
  wire       access  = psel && penable;

  assign pready  = 1'b1;
  assign pslverr = access && (hdr ? pwrite : (!bank_ok || (pwrite && idx == 4'd0)));
  wire   wr_ok   = access && pwrite && !pslverr;

  assign reg_wr    = wr_ok && idx >= 4'd3;
  assign reg_bank  = 8'(bank);
  assign reg_idx   = 3'(idx - 4'd3);
  assign reg_wdata = pwdata;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      out_q <= '0;
      dir_q <= '0;
    end else if (wr_ok) begin
      if (idx == 4'd1) out_q[32*bsel +: 32] <= pwdata & OCAP[32*bsel +: 32];
      if (idx == 4'd2) dir_q[32*bsel +: 32] <= pwdata & OCAP[32*bsel +: 32];
    end
  end

  always_comb begin
    prdata = '0;
    if (hdr) begin
      case (word[1:0])
        2'd0:    prdata = {8'h00, 8'h08, IP_ID};
        2'd1:    prdata = {8'h01, 8'h00, 16'h0000};
        default: prdata = {16'(NB), 16'(WIDTH)};
      endcase
    end else if (bank_ok) begin
      case (idx)
        4'd0:    prdata = in_all[32*bsel +: 32];
        4'd1:    prdata = out_q[32*bsel +: 32];
        4'd2:    prdata = dir_q[32*bsel +: 32];
        default: prdata = reg_rdata;
      endcase
    end
  end

  assign pad_out = WIDTH'(out_q);
  assign pad_oe  = WIDTH'(dir_q & OCAP) ^ {WIDTH{OE_ACTIVE_LOW}};

  p_err_no_write_r8: assert property (@(posedge pclk) disable iff (!presetn)
    (access && pwrite && pslverr) |=> ($stable(out_q) && $stable(dir_q)));

  p_read_quiet_r3: assert property (@(posedge pclk) disable iff (!presetn)
    (access && !pwrite) |=> ($stable(out_q) && $stable(dir_q)));

  p_dir_bank0_r3: assert property (@(posedge pclk) disable iff (!presetn)
    (access && pwrite && !pslverr && paddr == 12'h014) |=> dir_q[31:0] == ($past(pwdata) & OCAP[31:0]));

  p_no_drive_cap_r4: assert property (@(posedge pclk) disable iff (!presetn)
    ((pad_oe ^ {WIDTH{OE_ACTIVE_LOW}}) & ~OUT_CAP) == '0);
endmodule

// File: tb/gpio_bank_ctrl_test.sv
module gpio_bank_ctrl_test;
  localparam int W = 40;
  localparam logic [W-1:0] OC = 40'hF0_FFFF_FF0F;
  localparam logic [W-1:0] IC = 40'h0F_FFFF_FFFE;
  localparam logic [31:0] EXT = 32'hC0DE_5A17;

  logic clk = 0, rstn = 0;
  logic psel = 0, psel2 = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [W-1:0] pad_in = '0;
  logic [7:0] pad_in2 = '0;
  logic [31:0] prdata, prdata2, reg_wdata, reg_wdata2;
  logic pready, pslverr, pready2, pslverr2, reg_wr, reg_wr2;
  logic [W-1:0] pad_out, pad_oe, pin_level;
  logic [7:0] pad_out2, pad_oe2, pin_level2, reg_bank, reg_bank2;
  logic [2:0] reg_idx, reg_idx2;

  int checks = 0, fails = 0;
  logic [31:0] rd; logic er, sw; logic [7:0] sb; logic [2:0] si;

  always #10 clk = ~clk;

  gpio_bank_ctrl #(.WIDTH(W), .SYNC_STAGES(2), .OUT_CAP(OC), .IN_CAP(IC),
    .OE_ACTIVE_LOW(1'b0), .IP_ID(16'hBEEF)) uut (
    .pclk(clk), .presetn(rstn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pin_level(pin_level),
    .reg_wr(reg_wr), .reg_bank(reg_bank), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(EXT));

  gpio_bank_ctrl #(.WIDTH(8), .SYNC_STAGES(0), .OE_ACTIVE_LOW(1'b1)) uut2 (
    .pclk(clk), .presetn(rstn), .psel(psel2), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata2), .pready(pready2), .pslverr(pslverr2),
    .pad_in(pad_in2), .pad_out(pad_out2), .pad_oe(pad_oe2), .pin_level(pin_level2),
    .reg_wr(reg_wr2), .reg_bank(reg_bank2), .reg_idx(reg_idx2), .reg_wdata(reg_wdata2),
    .reg_rdata(32'h0));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apb(input bit second, input bit wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = !second; psel2 = second; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    #1;
    rd = second ? prdata2 : prdata;
    er = second ? pslverr2 : pslverr;
    sw = reg_wr; sb = reg_bank; si = reg_idx;
    if (!second) check("R8 pready", pready, 1);
    @(negedge clk);
    psel = 0; psel2 = 0; penable = 0; pwrite = 0;
  endtask

  task automatic t_reset;
    check("R10 out", pad_out, 0);
    check("R10 oe", pad_oe, 0);
    check("R6 oe low reset", pad_oe2, 8'hFF);
    apb(0, 0, 12'h010, 0); check("R10 out reg", rd, 0);
    apb(0, 0, 12'h040, 0); check("R10 dir reg", rd, 0);
  endtask

  task automatic t_header;
    apb(0, 0, 12'h000, 0); check("R1 word0", rd, 32'h0008_BEEF); check("R1 err", er, 0);
    apb(0, 0, 12'h004, 0); check("R1 word1", rd, 32'h0100_0000);
    apb(0, 0, 12'h008, 0); check("R2 word2", rd, 32'h0002_0028);
    apb(1, 0, 12'h008, 0); check("R2 small", rd, 32'h0001_0008);
  endtask

  task automatic t_regs;
    apb(0, 1, 12'h010, 32'hFFFF_FFFF); check("R3 wr err", er, 0);
    apb(0, 0, 12'h010, 0); check("R5 out bank0", rd, 32'hFFFF_FF0F);
    apb(0, 1, 12'h03C, 32'hFFFF_FFFF);
    apb(0, 0, 12'h03C, 0); check("R5 out bank1", rd, 32'h0000_00F0);
    apb(0, 1, 12'h010, 32'h1234_5608);
    apb(0, 0, 12'h010, 0); check("R3 out bank0", rd, 32'h1234_5608);
    check("R4 pad_out", pad_out, 40'hF0_1234_5608);
    apb(0, 1, 12'h014, 32'h0000_00FF);
    apb(0, 0, 12'h014, 0); check("R3 dir bank0", rd, 32'h0000_000F);
    check("R4 oe", pad_oe, 40'h00_0000_000F);
    apb(0, 1, 12'h040, 32'hFFFF_FFFF);
    apb(0, 0, 12'h040, 0); check("R5 dir bank1", rd, 32'h0000_00F0);
    check("R4 oe bank1", pad_oe, 40'hF0_0000_000F);
    apb(0, 1, 12'h014, 32'h0);
    check("R4 dir0 release", pad_oe, 40'hF0_0000_0000);
  endtask

  task automatic t_errors;
    apb(0, 1, 12'h000, 32'h1); check("R8 hdr write err", er, 1);
    apb(0, 1, 12'h00C, 32'h1); check("R8 input write err", er, 1);
    apb(0, 0, 12'h064, 0); check("R8 unmapped read err", er, 1); check("R8 unmapped data", rd, 0);
    apb(0, 1, 12'h064, 32'h0); check("R8 unmapped write err", er, 1);
    apb(0, 1, 12'h010, 32'h0); apb(0, 1, 12'h3FC, 32'hFFFF_FFFF);
    check("R8 err no write", pad_out, 40'hF0_0000_0000);
    check("R8 err no dir", pad_oe, 40'hF0_0000_0000);
  endtask

  task automatic t_sync;
    @(negedge clk); pad_in = 40'hFF_A5A5_A5A5; #1;
    check("R7 delay0", pin_level, 0);
    @(posedge clk); @(negedge clk); #1;
    check("R7 delay1", pin_level, 0);
    @(posedge clk); @(negedge clk); #1;
    check("R7 delay2", pin_level, 40'h0F_A5A5_A5A4);
    apb(0, 0, 12'h00C, 0); check("R5 in bank0", rd, 32'hA5A5_A5A4);
    apb(0, 0, 12'h038, 0); check("R5 in bank1", rd, 32'h0000_000F);
    pad_in2 = 8'h3C; #1; check("R7 zero stages", pin_level2, 8'h3C);
  endtask

  task automatic t_ext;
    apb(0, 1, 12'h044, 32'h55); check("R9 strobe", sw, 1);
    check("R9 bank", sb, 1); check("R9 idx", si, 0);
    apb(0, 1, 12'h034, 32'h66); check("R9 strobe b0", sw, 1);
    check("R9 bank0", sb, 0); check("R9 idx7", si, 7);
    apb(0, 0, 12'h060, 0); check("R9 read", rd, EXT); check("R9 rd no strobe", sw, 0);
    apb(0, 1, 12'h010, 32'h1); check("R9 no strobe", sw, 0);
  endtask

  task automatic t_low;
    apb(1, 1, 12'h014, 32'h0F);
    check("R6 oe inverted", pad_oe2, 8'hF0);
    apb(1, 1, 12'h010, 32'hA5);
    check("R6 out", pad_out2, 8'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstn = 1;
    t_reset(); t_header(); t_regs(); t_errors(); t_sync(); t_ext(); t_low();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule